// File: doc/BRIEF.md
# Gated Receiver Gain Loop

This block closes a gain loop around an external variable-gain amplifier that sits in front of an ADC. It takes one signed ADC sample per clock and averages the sample magnitude over a window of 2^K samples. At the end of each window it compares that average with a programmed target level. When the level is too low it raises a 3-bit gain code by one, and when it is too high it lowers the code by one. A deadband around the target sets the region where nothing changes. A hysteresis term makes a further step in the same direction harder to reach.

Each change of the gain code goes to the amplifier through an active-low latch strobe. The strobe starts one clock after the new code appears and lasts two clocks. The loop can run on every window. It can also run in a gated mode, where a falling edge on an active-low enable arms a counter of windows. When that counter is empty the loop keeps its last code. All settings are plain inputs and are meant to be held stable between resets.

Top module: `rx_gain_loop`

## Requirements
- R1: While reset is low, the gain code is 0 and the latch strobe is held low (active). At the first clock edge after reset is released the strobe goes high, and the code stays 0.
- R2: The level is the sum of two's-complement magnitudes over 2^K consecutive samples, shifted right by K. K is `tcLog2`, limited to `TC_MAX`. The most negative sample counts as magnitude 2^(SAMPLE_W-1). Windows follow one another back to back from reset.
- R3: When a window's level is strictly below threshold minus deadband, the code rises by one. It never rises above 7.
- R4: When a window's level is strictly above threshold plus deadband, the code falls by one. It never falls below 0.
- R5: After a rise, the lower limit is moved down by `hyst`. After a fall, the upper limit is moved up by `hyst`. Before the first step, neither limit is moved.
- R6: A request to rise at code 7, or to fall at code 0, leaves the code unchanged and issues no strobe. The code only ever moves by exactly one.
- R7: The new code is set up on the clock edge that follows the end of the window. The strobe goes low one clock later and stays low for exactly two clocks. There is one strobe pulse for every change of the code, and the code does not change while the strobe is low.
- R8: With `gatedMode`=1 the loop makes no steps after reset. A falling edge on `agcEnN` loads `gateWindows` into the window counter. It also discards the sample taken on that edge and starts a new window. The loop then acts on exactly the next `gateWindows` windows and holds its code after that.
- R9: A falling edge of the enable can land on the same edge on which a window's decision is applied. In that case the decision is judged against the old counter value, and the counter is reloaded, not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | SAMPLE_W | Signed ADC sample |
| tcLog2 | input | TC_W | Averaging window exponent K |
| thresh | input | SAMPLE_W | Target level (unsigned magnitude) |
| deadband | input | SAMPLE_W | Half-width of the no-step band |
| hyst | input | SAMPLE_W | Extra widening after a step in the same direction |
| gatedMode | input | 1 | 1 selects the gated (counted) mode |
| agcEnN | input | 1 | Active-low enable; its falling edge arms the gated loop |
| gateWindows | input | GATE_W | Number of windows the loop runs after an enable edge |
| gainCode | output | 3 | Gain code to the amplifier |
| gainStrobeN | output | 1 | Active-low latch strobe for the gain code |

## Verification
Two functions can fall on the same edge: the rearming of the window counter by an enable edge, and the application of a window's decision. The bench produces this by pulling the enable low in the cycle just after the last sample of a window. It does this once with an empty counter, where no step must occur, and once with a counter value of one, where the step must happen and the loop must then run a full count again. The scoreboard model applies the decision first and then reloads the counter. It judges the outcome by the gain steps that arrive, or do not arrive, in the windows that follow.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } stepDir_e;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;   // drop the running window and start a new one
    logic lastUp;    // last applied step was a rise
    logic lastDown;  // last applied step was a fall
  } ctl2dp_t;

  // datapath -> control strobes
  typedef struct packed {
    logic evalPulse; // a window average is ready this cycle
    logic wantUp;    // level below the lower limit
    logic wantDown;  // level above the upper limit
  } dp2ctl_t;

endpackage

// File: rtl/agc_level_path.sv
`timescale 1ns/1ps
module agc_level_path
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int TC_MAX   = 10,
  parameter int TC_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [TC_W-1:0]            tcLog2,
  input  logic [SAMPLE_W-1:0]        thresh,
  input  logic [SAMPLE_W-1:0]        deadband,
  input  logic [SAMPLE_W-1:0]        hyst,
  input  ctl2dp_t                    ctlIn,
  output dp2ctl_t                    dpOut
);

  localparam int ACC_W = SAMPLE_W + TC_MAX;
  localparam int CMP_W = SAMPLE_W + 3;
  localparam int CNT_W = TC_MAX + 1;

  logic [TC_W-1:0]         kEff;
  logic [CNT_W-1:0]        winLast;
  logic [CNT_W-1:0]        winCnt;
  logic [SAMPLE_W-1:0]     sampleMag;
  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        accSum;
  logic [SAMPLE_W-1:0]     avgReg;
  logic                    evalPulse;
  logic signed [CMP_W-1:0] avgWide;
  logic signed [CMP_W-1:0] loLimit;
  logic signed [CMP_W-1:0] hiLimit;

  function automatic logic signed [CMP_W-1:0] widen(input logic [SAMPLE_W-1:0] v);
    return $signed({3'b000, v});
  endfunction

  // clamp the window exponent
  always_comb begin
    if (tcLog2 > TC_W'(TC_MAX)) kEff = TC_W'(TC_MAX);
    else                        kEff = tcLog2;
  end

  always_comb winLast = (CNT_W'(1) << kEff) - CNT_W'(1);

  // two's-complement magnitude; the most negative code maps onto 2^(W-1)
  always_comb begin
    if (sampleIn[SAMPLE_W-1]) sampleMag = SAMPLE_W'(-sampleIn);
    else                      sampleMag = SAMPLE_W'(sampleIn);
  end

  always_comb accSum = acc + ACC_W'(sampleMag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      winCnt    <= '0;
      avgReg    <= '0;
      evalPulse <= 1'b0;
    end else if (ctlIn.restart) begin
      acc       <= '0;
      winCnt    <= '0;
      evalPulse <= 1'b0;
    end else if (winCnt == winLast) begin
      acc       <= '0;
      winCnt    <= '0;
      avgReg    <= SAMPLE_W'(accSum >> kEff);
      evalPulse <= 1'b1;
    end else begin
      acc       <= accSum;
      winCnt    <= winCnt + CNT_W'(1);
      evalPulse <= 1'b0;
    end
  end

  // limits, widened on the side of the last step
  always_comb begin
    avgWide = widen(avgReg);
    loLimit = widen(thresh) - widen(deadband);
    hiLimit = widen(thresh) + widen(deadband);
    if (ctlIn.lastUp)   loLimit = loLimit - widen(hyst);
    if (ctlIn.lastDown) hiLimit = hiLimit + widen(hyst);
  end

  always_comb begin
    dpOut.evalPulse = evalPulse;
    dpOut.wantUp    = evalPulse && (avgWide < loLimit);
    dpOut.wantDown  = evalPulse && (avgWide > hiLimit);
  end

  // R3/R4: the two requests never coexist
  p_exclusive_request_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(dpOut.wantUp && dpOut.wantDown))
    else $error("p_exclusive_request_r3");

endmodule

// File: rtl/agc_step_ctrl.sv
`timescale 1ns/1ps
module agc_step_ctrl
  import agc_pkg::*;
#(
  parameter int GATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gatedMode,
  input  logic              agcEnN,
  input  logic [GATE_W-1:0] gateWindows,
  input  dp2ctl_t           dpIn,
  output ctl2dp_t           ctlOut,
  output logic [2:0]        gainCode,
  output logic              gainStrobeN
);

  localparam logic [2:0] GAIN_TOP = 3'd7;
  localparam logic [2:0] GAIN_BOT = 3'd0;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW1  = 2'd2,
    PH_LOW2  = 2'd3
  } strobePh_e;

  strobePh_e         phase;
  stepDir_e          lastDir;
  logic [GATE_W-1:0] gateCnt;
  logic              enPrev;
  logic              enFall;
  logic              loopLive;
  logic              busy;
  logic              stepUp;
  logic              stepDown;

  always_comb begin
    enFall   = gatedMode && enPrev && !agcEnN;
    loopLive = !gatedMode || (gateCnt != '0);
    busy     = (phase != PH_IDLE);
    stepUp   = dpIn.wantUp   && loopLive && !busy && (gainCode != GAIN_TOP);
    stepDown = dpIn.wantDown && loopLive && !busy && (gainCode != GAIN_BOT);
  end

  always_comb begin
    ctlOut.restart  = enFall;
    ctlOut.lastUp   = (lastDir == DIR_UP);
    ctlOut.lastDown = (lastDir == DIR_DOWN);
  end

  // enable edge detector and window counter; reload wins over decrement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b1;
      gateCnt <= '0;
    end else begin
      enPrev <= agcEnN;
      if (enFall)
        gateCnt <= gateWindows;
      else if (gatedMode && dpIn.evalPulse && (gateCnt != '0))
        gateCnt <= gateCnt - GATE_W'(1);
    end
  end

  // gain code register and last direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainCode <= GAIN_BOT;
      lastDir  <= DIR_NONE;
    end else if (stepUp) begin
      gainCode <= gainCode + 3'd1;
      lastDir  <= DIR_UP;
    end else if (stepDown) begin
      gainCode <= gainCode - 3'd1;
      lastDir  <= DIR_DOWN;
    end
  end

  // strobe sequencer: one setup clock, then two clocks low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      gainStrobeN <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          gainStrobeN <= 1'b1;
          if (stepUp || stepDown) phase <= PH_SETUP;
        end
        PH_SETUP: begin
          gainStrobeN <= 1'b0;
          phase       <= PH_LOW1;
        end
        PH_LOW1: begin
          phase <= PH_LOW2;
        end
        default: begin
          gainStrobeN <= 1'b1;
          phase       <= PH_IDLE;
        end
      endcase
    end
  end

  p_strobe_follows_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gainCode != $past(gainCode)) |=> $fell(gainStrobeN))
    else $error("p_strobe_follows_change_r7");

  p_code_stable_in_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gainStrobeN |-> $stable(gainCode))
    else $error("p_code_stable_in_strobe_r7");

  p_unit_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gainCode != $past(gainCode)) |->
      (({1'b0, gainCode} == {1'b0, $past(gainCode)} + 4'd1) ||
       ({1'b0, $past(gainCode)} == {1'b0, gainCode} + 4'd1)))
    else $error("p_unit_step_r6");

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gatedMode && (gateCnt == '0)) |=> $stable(gainCode))
    else $error("p_gate_hold_r8");

endmodule

// File: rtl/rx_gain_loop.sv
`timescale 1ns/1ps
module rx_gain_loop
  import agc_pkg::*;
#(
  parameter int  SAMPLE_W = 14,
  parameter int  TC_MAX   = 10,
  parameter int  GATE_W   = 16,
  localparam int TC_W     = $clog2(TC_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [TC_W-1:0]            tcLog2,
  input  logic [SAMPLE_W-1:0]        thresh,
  input  logic [SAMPLE_W-1:0]        deadband,
  input  logic [SAMPLE_W-1:0]        hyst,
  input  logic                       gatedMode,
  input  logic                       agcEnN,
  input  logic [GATE_W-1:0]          gateWindows,
  output logic [2:0]                 gainCode,
  output logic                       gainStrobeN
);

  ctl2dp_t ctlBus;
  dp2ctl_t dpBus;

  agc_level_path #(
    .SAMPLE_W (SAMPLE_W),
    .TC_MAX   (TC_MAX),
    .TC_W     (TC_W)
  ) levelPath_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .tcLog2   (tcLog2),
    .thresh   (thresh),
    .deadband (deadband),
    .hyst     (hyst),
    .ctlIn    (ctlBus),
    .dpOut    (dpBus)
  );

  agc_step_ctrl #(
    .GATE_W (GATE_W)
  ) stepCtrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .gatedMode   (gatedMode),
    .agcEnN      (agcEnN),
    .gateWindows (gateWindows),
    .dpIn        (dpBus),
    .ctlOut      (ctlBus),
    .gainCode    (gainCode),
    .gainStrobeN (gainStrobeN)
  );

endmodule

// File: tb/rx_gain_loop_tb_top.sv
`timescale 1ns/1ps
module rx_gain_loop_tb_top;

  localparam int SW = 14;
  localparam int TCM = 10;
  localparam int GW = 16;
  localparam int TW = $clog2(TCM + 1);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic [TW-1:0]        tcLog2 = TW'(2);
  logic [SW-1:0]        thresh = SW'(100);
  logic [SW-1:0]        deadband = SW'(10);
  logic [SW-1:0]        hyst = SW'(20);
  logic                 gatedMode = 1'b0;
  logic                 agcEnN = 1'b1;
  logic [GW-1:0]        gateWindows = GW'(3);
  logic [2:0]           gainCode;
  logic                 gainStrobeN;

  always #5 clk = ~clk;

  rx_gain_loop #(.SAMPLE_W(SW), .TC_MAX(TCM), .GATE_W(GW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .tcLog2(tcLog2),
    .thresh(thresh), .deadband(deadband), .hyst(hyst),
    .gatedMode(gatedMode), .agcEnN(agcEnN), .gateWindows(gateWindows),
    .gainCode(gainCode), .gainStrobeN(gainStrobeN)
  );

  int checks = 0;
  int fails = 0;
  int pushes = 0;
  int strobes = 0;
  int gainChanges = 0;
  bit finished = 1'b0;

  int expQ[$];
  string tagQ[$];
  string curTag = "R1";

  // reference model state
  int mGain, mDir, mGate, mK;
  bit mGated;
  localparam int THR = 100, DB = 10, HY = 20, GATE_N = 3;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_window(input int mag, input string tag);
    int lo, hi;
    bit live;
    live = !mGated || (mGate > 0);
    if (live) begin
      lo = THR - DB - ((mDir == 1) ? HY : 0);
      hi = THR + DB + ((mDir == 2) ? HY : 0);
      if (mag < lo && mGain < 7) begin
        mGain++; mDir = 1; expQ.push_back(mGain); tagQ.push_back(tag); pushes++;
      end else if (mag > hi && mGain > 0) begin
        mGain--; mDir = 2; expQ.push_back(mGain); tagQ.push_back(tag); pushes++;
      end
      if (mGated) mGate--;
    end
  endtask

  // one window of alternating-sign samples of magnitude |v|
  task automatic window(input int v, input string tag);
    int n;
    int mag;
    n = 1 << mK;
    mag = (v < 0) ? -v : v;
    curTag = tag;
    for (int i = 0; i < n; i++) begin
      if (v == -8192) sampleIn = SW'(v);
      else sampleIn = (i % 2 == 1) ? SW'(-v) : SW'(v);
      agcEnN = 1'b1;
      @(negedge clk);
    end
    model_window(mag, tag);
  endtask

  // enable pulse: its sample is discarded, counter reloads after the pending decision
  task automatic pulse_enable(input string tag);
    curTag = tag;
    agcEnN = 1'b0;
    sampleIn = '0;
    @(negedge clk);
    agcEnN = 1'b1;
    mGate = GATE_N;
  endtask

  task automatic drain();
    sampleIn = SW'(100);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input bit gated, input int k);
    rstN = 1'b0;
    gatedMode = gated;
    tcLog2 = TW'(k);
    agcEnN = 1'b1;
    sampleIn = '0;
    repeat (3) @(negedge clk);
    check(gainStrobeN == 1'b0, "R1 strobe active in reset", int'(gainStrobeN), 0);
    check(gainCode == 3'd0, "R1 code in reset", int'(gainCode), 0);
    mGain = 0; mDir = 0; mGate = 0; mK = k; mGated = gated;
    #1 rstN = 1'b1;
  endtask

  // scoreboard monitor
  bit pS;
  logic [2:0] pG, ppG;
  int lowRun;
  int armCnt;
  always @(negedge clk) begin
    if (!rstN) begin
      armCnt = 0;
      lowRun = 0;
    end else begin
      if (armCnt == 0) begin
        check(gainStrobeN == 1'b1, "R1 strobe after reset", int'(gainStrobeN), 1);
        check(gainCode == 3'd0, "R1 code after reset", int'(gainCode), 0);
      end else begin
        if (gainCode != pG) gainChanges++;
        if (pS && !gainStrobeN) begin
          strobes++;
          lowRun = 1;
          if (expQ.size() == 0) begin
            check(1'b0, {curTag, " R6/R7 unexpected strobe"}, int'(gainCode), int'(pG));
          end else begin
            int e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(gainCode == 3'(e), {t, " gain code"}, int'(gainCode), e);
            check(pG == gainCode, "R7 code set up before strobe", int'(pG), int'(gainCode));
            if (armCnt >= 2)
              check(ppG != gainCode, "R7 strobe one clock after change", int'(ppG), -1);
          end
        end else if (!pS && !gainStrobeN) begin
          lowRun++;
        end else if (!pS && gainStrobeN && lowRun > 0) begin
          check(lowRun == 2, "R7 strobe width", lowRun, 2);
          lowRun = 0;
        end
      end
      ppG = pG;
      pG = gainCode;
      pS = gainStrobeN;
      armCnt++;
    end
  end

  initial begin
    // continuous mode, K=2
    do_reset(1'b0, 2);
    window(100, "R2");
    window(90, "R3");       // equal to lower limit: no step
    window(85, "R3");       // rise to 1
    window(85, "R5");       // lower limit now 70: hold
    window(65, "R5");       // rise to 2
    window(115, "R4");      // fall to 1
    window(115, "R5");      // upper limit now 130: hold
    window(135, "R5");      // fall to 0
    window(200, "R6");      // bottom saturation
    for (int i = 0; i < 9; i++) window(0, "R6"); // rise to 7, then hold
    window(-8192, "R2");    // most negative sample: fall to 6
    drain();
    check(expQ.size() == 0, "R7 all steps strobed (continuous)", expQ.size(), 0);

    // gated mode, K=3
    do_reset(1'b1, 3);
    window(0, "R8");        // idle after reset
    window(0, "R8");
    pulse_enable("R8");
    for (int i = 0; i < 5; i++) window(0, "R8"); // three rises then hold
    pulse_enable("R9");     // coincides with a decision at an empty counter
    window(200, "R8");
    window(200, "R8");
    window(200, "R9");      // counter at one: step applied
    pulse_enable("R9");     // same edge reloads the counter
    for (int i = 0; i < 4; i++) window(0, "R9");
    drain();
    check(expQ.size() == 0, "R7 all steps strobed (gated)", expQ.size(), 0);
    check(strobes == gainChanges, "R7 one strobe per code change", strobes, gainChanges);
    check(pushes == strobes, "R7 strobe count", strobes, pushes);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule